// File: doc/BRIEF.md
# Receive Holding Queue with Line Status

This block sits between a serial receiver and a host. Each character that the receiver delivers is queued together with the three error flags it arrived with: bad parity, bad stop bit and line break. The host sees the oldest character on the head output and removes it with a pop strobe. A small set of status bits tells the host whether data is waiting, whether a character was lost because the queue was full, and which errors belong to the character now at the head.

The error bits are not live receiver flags. A flag stays hidden while its character waits behind older ones. It appears only when that character reaches the head. A status-read strobe clears every error bit for the current head, and the same head cannot raise them again. In nine-bit mode the parity position shows the ninth data bit of the head, and a status read does not clear it. The transmit-empty status bit is a direct copy of an input.

Top module: `rxq_line_status`

## Requirements
- R1: After reset the queue is empty and dataAvail, overrun, parityBit, frameBit and breakBit are all 0.
- R2: Characters leave in the order they arrived. headData shows the oldest stored character, and dataAvail is 1 exactly when at least one character is stored. At most DEPTH characters are held.
- R3: If chValid arrives while DEPTH characters are held and no pop is taken at the same edge, the character is dropped and overrun reads 1 from the next cycle. A pop at the same edge makes room, and the character is then stored.
- R4: In normal mode (nineBitMode=0), parityBit and frameBit show the parity and stop-bit flags stored with the head character. They are 0 while the faulty character is not yet at the head.
- R5: breakBit shows the break flag stored with the head character, under the same rule as R4.
- R6: A statusRd strobe clears overrun, parityBit, frameBit and breakBit from the next cycle. If an overrun event falls on the same edge, overrun reads 1.
- R7: Flags cleared by statusRd stay 0 while the same character remains at the head. When a new character becomes the head, its own flags are shown, even if a read was taken on that same edge.
- R8: With nineBitMode=1, parityBit equals headData[DATA_W-1] (the ninth bit, bit 8 by default) of the head character. The stored parity flag is ignored, and statusRd does not clear the bit.
- R9: A pop while the queue is empty has no effect. A later character becomes the head as normal.
- R10: txEmptyBit always equals the txEmpty input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nineBitMode | input | 1 | 1 selects nine-bit framing display |
| chValid | input | 1 | Receiver delivers a character this cycle |
| chData | input | DATA_W | Received character, top bit is the ninth bit |
| chParityErr | input | 1 | Parity error flag of the character |
| chFrameErr | input | 1 | Stop-bit error flag of the character |
| chBreak | input | 1 | Break flag of the character |
| popReq | input | 1 | Host removes the head character |
| statusRd | input | 1 | Host reads the status bits |
| txEmpty | input | 1 | Transmit side is empty |
| headData | output | DATA_W | Oldest stored character |
| dataAvail | output | 1 | At least one character stored |
| overrun | output | 1 | A character was dropped on a full queue |
| parityBit | output | 1 | Head parity error, or ninth bit in nine-bit mode |
| frameBit | output | 1 | Head stop-bit error |
| breakBit | output | 1 | Head break flag |
| txEmptyBit | output | 1 | Copy of txEmpty |

## Verification
Two cases can fall on one edge. In the first, a character arrives on a full queue while the host pops, so the queue has room and no overrun may appear. In the second, the host reads status while the head moves on or an overrun occurs, so the new head's flags or the new overrun must stay visible. The bench drives each pair in one cycle. It checks headData, overrun and the error bits in the cycle after, and then drains the queue to confirm the exact sequence of stored characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic parity;
    logic frame;
    logic brk;
  } rxqFlags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic headNew;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 9,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  rxqFlags_t         wrFlags,
  output logic [DATA_W-1:0] headData,
  output rxqFlags_t         headFlags,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] memData  [DEPTH];
  rxqFlags_t         memFlags [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) begin
      memData[wrPtr]  <= wrData;
      memFlags[wrPtr] <= wrFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData  = memData[rdPtr];
  assign headFlags = memFlags[rdPtr];
endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chValid,
  input  logic             popReq,
  input  logic             statusRd,
  input  logic             nineBitMode,
  input  logic [CNT_W-1:0] count,
  input  rxqFlags_t        headFlags,
  input  logic             headBit9,
  output rxqStrobe_t       strb,
  output logic             dataAvail,
  output logic             overrun,
  output logic             parityBit,
  output logic             frameBit,
  output logic             breakBit
);
  logic      isEmpty;
  logic      isFull;
  logic      ovrEvent;
  rxqFlags_t clrMask;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_W'(DEPTH));

  always_comb begin
    strb.pop     = popReq & ~isEmpty;
    strb.push    = chValid & (~isFull | strb.pop);
    strb.headNew = strb.pop | (strb.push & isEmpty);
  end

  assign ovrEvent = chValid & isFull & ~strb.pop;

  always_ff @(posedge clk) begin
    if (!rstN)         overrun <= 1'b0;
    else if (ovrEvent) overrun <= 1'b1;
    else if (statusRd) overrun <= 1'b0;
  end

  // A head change re-arms the flags; a read masks them for the current head.
  always_ff @(posedge clk) begin
    if (!rstN)              clrMask <= '0;
    else if (strb.headNew)  clrMask <= '0;
    else if (statusRd)      clrMask <= '1;
  end

  assign dataAvail = ~isEmpty;
  assign frameBit  = ~isEmpty & headFlags.frame & ~clrMask.frame;
  assign breakBit  = ~isEmpty & headFlags.brk   & ~clrMask.brk;
  assign parityBit = nineBitMode ? (~isEmpty & headBit9)
                                 : (~isEmpty & headFlags.parity & ~clrMask.parity);
endmodule

// File: rtl/rxq_line_status.sv
module rxq_line_status
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nineBitMode,
  input  logic              chValid,
  input  logic [DATA_W-1:0] chData,
  input  logic              chParityErr,
  input  logic              chFrameErr,
  input  logic              chBreak,
  input  logic              popReq,
  input  logic              statusRd,
  input  logic              txEmpty,
  output logic [DATA_W-1:0] headData,
  output logic              dataAvail,
  output logic              overrun,
  output logic              parityBit,
  output logic              frameBit,
  output logic              breakBit,
  output logic              txEmptyBit
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxqStrobe_t       strb;
  rxqFlags_t        wrFlags;
  rxqFlags_t        headFlags;
  logic [CNT_W-1:0] count;

  assign wrFlags = '{parity: chParityErr, frame: chFrameErr, brk: chBreak};

  rxq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (chData),
    .wrFlags   (wrFlags),
    .headData  (headData),
    .headFlags (headFlags),
    .count     (count)
  );

  rxq_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .chValid     (chValid),
    .popReq      (popReq),
    .statusRd    (statusRd),
    .nineBitMode (nineBitMode),
    .count       (count),
    .headFlags   (headFlags),
    .headBit9    (headData[DATA_W-1]),
    .strb        (strb),
    .dataAvail   (dataAvail),
    .overrun     (overrun),
    .parityBit   (parityBit),
    .frameBit    (frameBit),
    .breakBit    (breakBit)
  );

  assign txEmptyBit = txEmpty;
endmodule

// File: rtl/rxq_line_status_chk.sv
module rxq_line_status_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             chValid,
  input logic             popReq,
  input logic             statusRd,
  input logic             nineBitMode,
  input logic             overrun,
  input logic             parityBit,
  input logic             frameBit,
  input logic             breakBit,
  input logic [CNT_W-1:0] count
);
  logic fullNow;
  assign fullNow = (count == CNT_W'(DEPTH));

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R2

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    chValid && fullNow && !popReq |=> overrun); // R3

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    chValid && fullNow && !popReq |=> fullNow); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !(chValid && fullNow && !popReq) |=> !overrun); // R6

  AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !popReq && count != '0 |=> !frameBit && !breakBit); // R7

  AST_NINE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    nineBitMode && statusRd && !popReq && parityBit |=> parityBit || !nineBitMode); // R8

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    count == '0 && popReq && !chValid |=> count == '0); // R9
endmodule

bind rxq_line_status rxq_line_status_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .chValid     (chValid),
  .popReq      (popReq),
  .statusRd    (statusRd),
  .nineBitMode (nineBitMode),
  .overrun     (overrun),
  .parityBit   (parityBit),
  .frameBit    (frameBit),
  .breakBit    (breakBit),
  .count       (count)
);

// File: tb/tb_rxq_line_status.sv
module tb_rxq_line_status;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              nineBitMode = 1'b0;
  logic              chValid = 1'b0;
  logic [DATA_W-1:0] chData = '0;
  logic              chParityErr = 1'b0;
  logic              chFrameErr = 1'b0;
  logic              chBreak = 1'b0;
  logic              popReq = 1'b0;
  logic              statusRd = 1'b0;
  logic              txEmpty = 1'b0;
  logic [DATA_W-1:0] headData;
  logic              dataAvail, overrun, parityBit, frameBit, breakBit, txEmptyBit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rxq_line_status #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .nineBitMode(nineBitMode), .chValid(chValid),
    .chData(chData), .chParityErr(chParityErr), .chFrameErr(chFrameErr),
    .chBreak(chBreak), .popReq(popReq), .statusRd(statusRd), .txEmpty(txEmpty),
    .headData(headData), .dataAvail(dataAvail), .overrun(overrun),
    .parityBit(parityBit), .frameBit(frameBit), .breakBit(breakBit),
    .txEmptyBit(txEmptyBit)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chValid = 1'b0; popReq = 1'b0; statusRd = 1'b0;
    chParityErr = 1'b0; chFrameErr = 1'b0; chBreak = 1'b0;
  endtask

  task automatic setChar(input logic [DATA_W-1:0] d, input logic p, input logic f, input logic b);
    chValid = 1'b1; chData = d; chParityErr = p; chFrameErr = f; chBreak = b;
  endtask

  task automatic testReset();
    check("R1 dataAvail after reset", dataAvail, 0);
    check("R1 overrun after reset", overrun, 0);
    check("R1 error bits after reset", {parityBit, frameBit, breakBit}, 0);
  endtask

  task automatic testOrder();
    setChar(9'h0A1, 0, 0, 0); cyc();
    setChar(9'h1B2, 0, 0, 0); cyc();
    setChar(9'h0C3, 0, 0, 0); cyc();
    check("R2 head is first", headData, 9'h0A1);
    check("R2 dataAvail", dataAvail, 1);
    popReq = 1; cyc();
    check("R2 head second", headData, 9'h1B2);
    popReq = 1; cyc();
    check("R2 head third", headData, 9'h0C3);
    popReq = 1; cyc();
    check("R2 empty after drain", dataAvail, 0);
  endtask

  task automatic testFlags();
    setChar(9'h011, 0, 0, 0); cyc();
    setChar(9'h022, 1, 0, 0); cyc();
    setChar(9'h033, 0, 1, 1); cyc();
    check("R4 hidden behind clean head", {parityBit, frameBit}, 0);
    check("R5 break hidden behind head", breakBit, 0);
    popReq = 1; cyc();
    check("R4 parity at head", parityBit, 1);
    check("R4 frame clear for parity head", frameBit, 0);
    statusRd = 1; cyc();
    check("R6 parity cleared by read", parityBit, 0);
    cyc();
    check("R7 parity stays clear", parityBit, 0);
    popReq = 1; statusRd = 1; cyc();
    check("R7 new head frame shown", frameBit, 1);
    check("R5 break at head", breakBit, 1);
    statusRd = 1; cyc();
    check("R6 frame and break cleared", {frameBit, breakBit}, 0);
    popReq = 1; cyc();
    check("R2 empty after flags test", dataAvail, 0);
  endtask

  task automatic testOverrun();
    for (int i = 0; i < DEPTH; i++) begin
      setChar(DATA_W'(i), 0, 0, 0); cyc();
    end
    check("R3 no overrun when just full", overrun, 0);
    setChar(9'h1AA, 0, 0, 0); cyc();
    check("R3 overrun set", overrun, 1);
    check("R3 head unchanged", headData, 0);
    statusRd = 1; cyc();
    check("R6 overrun cleared", overrun, 0);
    setChar(9'h055, 0, 0, 0); popReq = 1; cyc();
    check("R3 push with pop no overrun", overrun, 0);
    check("R3 head after pop", headData, 1);
    setChar(9'h1EE, 0, 0, 0); statusRd = 1; cyc();
    check("R6 overrun wins over read", overrun, 1);
    for (int i = 1; i < DEPTH; i++) begin
      check("R3 drain order", headData, DATA_W'(i));
      popReq = 1; cyc();
    end
    check("R3 accepted char last", headData, 9'h055);
    popReq = 1; cyc();
    check("R3 dropped chars absent", dataAvail, 0);
    statusRd = 1; cyc();
  endtask

  task automatic testNine();
    nineBitMode = 1;
    setChar(9'h1C3, 0, 0, 0); cyc();
    check("R8 ninth bit shown", parityBit, 1);
    statusRd = 1; cyc();
    check("R8 ninth bit not cleared", parityBit, 1);
    setChar(9'h044, 1, 0, 0); cyc();
    popReq = 1; cyc();
    check("R8 parity flag ignored", parityBit, 0);
    popReq = 1; cyc();
    nineBitMode = 0;
    check("R8 empty after nine test", dataAvail, 0);
  endtask

  task automatic testPopEmpty();
    popReq = 1; cyc();
    check("R9 pop on empty", dataAvail, 0);
    popReq = 1; cyc();
    setChar(9'h0AB, 0, 0, 0); cyc();
    check("R9 head after empty pops", headData, 9'h0AB);
    check("R9 one char stored", dataAvail, 1);
    popReq = 1; cyc();
    check("R9 empty again", dataAvail, 0);
  endtask

  task automatic testTx();
    txEmpty = 1; #1;
    check("R10 txEmpty high", txEmptyBit, 1);
    txEmpty = 0; #1;
    check("R10 txEmpty low", txEmptyBit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrder();
    testFlags();
    testOverrun();
    testNine();
    testPopEmpty();
    testTx();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule